// File: doc/BRIEF.md
# Programmable-Depth Bit Elastic Store

This block is a one-bit-wide circular buffer that sits between a jittery line clock and a smoothed clock produced by an external clock adapter. Serial bits enter on the write clock and leave on the read clock. The write clock is either the receive clock or the transmit clock, chosen by a direction select. The read side always runs on the dejittered clock. A 3-bit size code sets the usable depth at run time, from 8 to 128 bits.

The write and read pointers are free-running counters. Each is reduced modulo the selected depth to index storage. The write pointer crosses into the read domain in Gray code through a two-flop synchronizer. The read domain then turns the pointer distance into a signed phase error, measured from the centred position, for the clock adapter to steer on. A write to a full buffer is an overflow. A read from an empty buffer is an underrun. Either one sets a sticky error flag, and a second flag records which of the two happened last. Holding the centre command puts the write pointer at 0 and the read pointer at half depth, which restores mid-depth operation.

Inputs `center_i`, `clr_err_i` and `rd_en_i` are synchronous to `jclk_i`. Inputs `wr_en_i` and `wr_data_i` are synchronous to the selected write clock. The size code and the direction are quasi-static. A new size takes effect cleanly only after a centring.

Top module: `bit_elastic_store`

## Requirements
- R1: The size code maps to a depth as follows: 0 to 8, 1 to 16, 2 to 32, 3 to 64 and 4 to 128 bits. Codes 5, 6 and 7 also give 128.
- R2: After reset both pointers are 0, so the buffer is empty. `phase_o` then reads minus half the depth, and `err_o`, `lim_full_o` and `rd_data_o` are all 0.
- R3: `phase_o` is an 8-bit two's-complement value equal to the occupancy minus half the depth. It is +depth/2 when the buffer is full and -depth/2 when it is empty, which is ±64 at depth 128.
- R4: While `center_i` is high, the write pointer is held at 0 and the read pointer at depth/2. `center_i` must be held for at least 3 write-clock cycles. Once it is released and the pointers have synchronized, `phase_o` is 0. Centring clears `lim_full_o` but leaves `err_o` unchanged.
- R5: Bits are read out in the order they were written, including across the wrap of the circular index.
- R6: A write while the buffer is full is dropped and the write pointer does not advance. It sets `err_o` to 1 and `lim_full_o` to 1.
- R7: A read while the buffer is empty leaves `rd_data_o` holding its last bit and does not advance the read pointer. It sets `err_o` to 1 and `lim_full_o` to 0.
- R8: `err_o` is sticky. Only a `clr_err_i` pulse or reset clears it, and a new limit event in the same cycle as the clear wins.
- R9: With `dir_tx_i`=0 the write side is clocked by `rx_clk_i`, and with `dir_tx_i`=1 it is clocked by `tx_clk_i`. The read side always uses `jclk_i`.
- R10: `rd_data_o` is registered on `jclk_i` and changes only on an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_clk_i | input | 1 | Receive line clock (write clock when dir_tx_i=0) |
| tx_clk_i | input | 1 | Transmit clock (write clock when dir_tx_i=1) |
| jclk_i | input | 1 | Dejittered read clock |
| dir_tx_i | input | 1 | Path select: 0 receive, 1 transmit |
| size_code_i | input | 3 | Depth select code |
| center_i | input | 1 | Centre command (level, read domain) |
| clr_err_i | input | 1 | Clear sticky error (read domain) |
| wr_en_i | input | 1 | Write strobe (write domain) |
| wr_data_i | input | 1 | Serial bit to store |
| rd_en_i | input | 1 | Read strobe (read domain) |
| rd_data_o | output | 1 | Registered output bit |
| phase_o | output | 8 | Signed phase error from centre |
| err_o | output | 1 | Sticky limit error |
| lim_full_o | output | 1 | Last limit event: 1 overflow, 0 underrun |

## Verification
The bench fills each depth from the centred point until it overflows. A wrong size decode or a wrong wrap mask then shows as a phase value other than +depth/2, and code 4 and codes 5 to 7 are each covered. It writes one extra bit after the buffer is exactly full, and it reads one extra bit after the buffer is drained. A design that stored the extra bit, or advanced a pointer on a limit event, would then shift the read-back sequence or change the held output bit. A centring after an overflow must clear the last-event flag but keep the sticky error, so a design that cleared both, or neither, is caught. Stopping the unselected write clock while writing shows whether the direction select really picks the pointer clock.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int unsigned MIN_DEPTH = 8;
  localparam int unsigned MAX_DEPTH = 128;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned IDX_W     = $clog2(MAX_DEPTH);
  localparam int unsigned CNT_W     = IDX_W + 1;
  localparam int unsigned NUM_SIZES = IDX_W - $clog2(MIN_DEPTH) + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t depth_of(input logic [CODE_W-1:0] code);
    if (code < CODE_W'(NUM_SIZES)) return cnt_t'(MIN_DEPTH) << code;
    return cnt_t'(MAX_DEPTH);
  endfunction

  function automatic cnt_t half_of(input logic [CODE_W-1:0] code);
    return depth_of(code) >> 1;
  endfunction

  function automatic cnt_t bin2gray(input cnt_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic cnt_t gray2bin(input cnt_t g);
    cnt_t b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/es_sync.sv
module es_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/es_wr_side.sv
module es_wr_side
  import es_pkg::*;
(
  input  logic                 wr_clk_i,
  input  logic                 rst_ni,
  input  logic [CODE_W-1:0]    size_code_i,
  input  logic                 center_i,
  input  logic                 wr_en_i,
  input  logic                 wr_data_i,
  input  cnt_t                 rptr_gray_i,
  output cnt_t                 wptr_gray_o,
  output logic [MAX_DEPTH-1:0] mem_o,
  output logic                 ovf_tgl_o
);
  logic             center_s, full;
  cnt_t             rg_s, r_bin, w_q, w_nxt, occ, depth;
  logic [IDX_W-1:0] mask, idx;

  es_sync #(.W(1)) u_ctr_sync (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(center_i), .q_o(center_s)
  );
  es_sync #(.W(CNT_W)) u_rptr_sync (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rptr_gray_i), .q_o(rg_s)
  );

  always_comb begin
    depth = depth_of(size_code_i);
    mask  = depth[IDX_W-1:0] - IDX_W'(1);
    r_bin = gray2bin(rg_s);
    occ   = w_q - r_bin;
    full  = (occ >= depth);   // stale read pointer only makes this conservative
    w_nxt = w_q + cnt_t'(1);
    idx   = w_q[IDX_W-1:0] & mask;
  end

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q         <= '0;
      wptr_gray_o <= '0;
      mem_o       <= '0;
      ovf_tgl_o   <= 1'b0;
    end else if (center_s) begin
      w_q         <= '0;
      wptr_gray_o <= '0;
    end else if (wr_en_i) begin
      if (full) begin
        ovf_tgl_o <= ~ovf_tgl_o;
      end else begin
        mem_o[idx]  <= wr_data_i;
        w_q         <= w_nxt;
        wptr_gray_o <= bin2gray(w_nxt);
      end
    end
  end
endmodule

// File: rtl/es_rd_side.sv
module es_rd_side
  import es_pkg::*;
(
  input  logic                 jclk_i,
  input  logic                 rst_ni,
  input  logic [CODE_W-1:0]    size_code_i,
  input  logic                 center_i,
  input  logic                 clr_err_i,
  input  logic                 rd_en_i,
  input  cnt_t                 wptr_gray_i,
  input  logic [MAX_DEPTH-1:0] mem_i,
  input  logic                 ovf_tgl_i,
  output cnt_t                 rptr_gray_o,
  output logic                 rd_data_o,
  output cnt_t                 phase_o,
  output logic                 err_o,
  output logic                 lim_full_o
);
  logic             ovf_s, ovf_d, ovf_evt, urun_evt, empty;
  cnt_t             wg_s, w_bin, r_q, r_nxt, occ, half, depth, ctr_ptr;
  logic [IDX_W-1:0] mask, idx;

  es_sync #(.W(CNT_W)) u_wptr_sync (
    .clk_i(jclk_i), .rst_ni(rst_ni), .d_i(wptr_gray_i), .q_o(wg_s)
  );
  es_sync #(.W(1)) u_ovf_sync (
    .clk_i(jclk_i), .rst_ni(rst_ni), .d_i(ovf_tgl_i), .q_o(ovf_s)
  );

  always_comb begin
    depth    = depth_of(size_code_i);
    half     = half_of(size_code_i);
    mask     = depth[IDX_W-1:0] - IDX_W'(1);
    w_bin    = gray2bin(wg_s);
    occ      = w_bin - r_q;
    empty    = (occ == '0);
    phase_o  = occ - half;
    r_nxt    = r_q + cnt_t'(1);
    ctr_ptr  = '0 - half;     // index lands on depth/2
    idx      = r_q[IDX_W-1:0] & mask;
    ovf_evt  = ovf_s ^ ovf_d;
    urun_evt = rd_en_i & empty & ~center_i;
  end

  always_ff @(posedge jclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q         <= '0;
      rptr_gray_o <= '0;
      rd_data_o   <= 1'b0;
    end else if (center_i) begin
      r_q         <= ctr_ptr;
      rptr_gray_o <= bin2gray(ctr_ptr);
    end else if (rd_en_i && !empty) begin
      rd_data_o   <= mem_i[idx];
      r_q         <= r_nxt;
      rptr_gray_o <= bin2gray(r_nxt);
    end
  end

  always_ff @(posedge jclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_d      <= 1'b0;
      err_o      <= 1'b0;
      lim_full_o <= 1'b0;
    end else begin
      ovf_d <= ovf_s;
      if (ovf_evt || urun_evt) err_o <= 1'b1;
      else if (clr_err_i)      err_o <= 1'b0;
      if (center_i)            lim_full_o <= 1'b0;
      else if (ovf_evt)        lim_full_o <= 1'b1;
      else if (urun_evt)       lim_full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bit_elastic_store.sv
module bit_elastic_store
  import es_pkg::*;
(
  input  logic              rst_ni,
  input  logic              rx_clk_i,
  input  logic              tx_clk_i,
  input  logic              jclk_i,
  input  logic              dir_tx_i,
  input  logic [CODE_W-1:0] size_code_i,
  input  logic              center_i,
  input  logic              clr_err_i,
  input  logic              wr_en_i,
  input  logic              wr_data_i,
  input  logic              rd_en_i,
  output logic              rd_data_o,
  output logic [CNT_W-1:0]  phase_o,
  output logic              err_o,
  output logic              lim_full_o
);
  logic                 wr_clk, ovf_tgl;
  cnt_t                 wptr_gray, rptr_gray, phase;
  logic [MAX_DEPTH-1:0] mem;

  assign wr_clk  = dir_tx_i ? tx_clk_i : rx_clk_i;
  assign phase_o = phase;

  es_wr_side u_wr (
    .wr_clk_i(wr_clk), .rst_ni(rst_ni), .size_code_i(size_code_i),
    .center_i(center_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rptr_gray_i(rptr_gray), .wptr_gray_o(wptr_gray), .mem_o(mem),
    .ovf_tgl_o(ovf_tgl)
  );

  es_rd_side u_rd (
    .jclk_i(jclk_i), .rst_ni(rst_ni), .size_code_i(size_code_i),
    .center_i(center_i), .clr_err_i(clr_err_i), .rd_en_i(rd_en_i),
    .wptr_gray_i(wptr_gray), .mem_i(mem), .ovf_tgl_i(ovf_tgl),
    .rptr_gray_o(rptr_gray), .rd_data_o(rd_data_o), .phase_o(phase),
    .err_o(err_o), .lim_full_o(lim_full_o)
  );
endmodule

// File: rtl/bit_elastic_store_chk.sv
module bit_elastic_store_chk
  import es_pkg::*;
(
  input logic              jclk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] size_code_i,
  input logic              center_i,
  input logic              clr_err_i,
  input logic              rd_en_i,
  input logic              rd_data_o,
  input logic [CNT_W-1:0]  phase_o,
  input logic              err_o,
  input logic              lim_full_o
);
  // R7
  hold_on_empty_chk: assert property (@(posedge jclk_i) disable iff (!rst_ni)
    (rd_en_i && phase_o == (cnt_t'(0) - half_of(size_code_i))) |=> $stable(rd_data_o));

  // R10
  idle_data_stable_chk: assert property (@(posedge jclk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R4
  center_clears_full_chk: assert property (@(posedge jclk_i) disable iff (!rst_ni)
    center_i |=> !lim_full_o);

  // R8
  err_sticky_chk: assert property (@(posedge jclk_i) disable iff (!rst_ni)
    (err_o && !clr_err_i) |=> err_o);

  // R8
  err_fall_chk: assert property (@(posedge jclk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(clr_err_i));

  // R6
  full_flag_err_chk: assert property (@(posedge jclk_i) disable iff (!rst_ni)
    $rose(lim_full_o) |-> err_o);
endmodule

bind bit_elastic_store bit_elastic_store_chk u_chk (
  .jclk_i(jclk_i), .rst_ni(rst_ni), .size_code_i(size_code_i),
  .center_i(center_i), .clr_err_i(clr_err_i), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .phase_o(phase_o), .err_o(err_o),
  .lim_full_o(lim_full_o)
);

// File: tb/bit_elastic_store_tb.sv
`timescale 1ns/1ps
module bit_elastic_store_tb;
  logic       rst_ni = 1'b0;
  logic       jclk = 1'b0, wclk = 1'b0, rx_run = 1'b1, tx_run = 1'b1;
  logic       rx_clk, tx_clk;
  logic       dir_tx = 1'b0, center = 1'b0, clr = 1'b0;
  logic       wr_en = 1'b0, wr_data = 1'b0, rd_en = 1'b0;
  logic [2:0] size = 3'd2;
  logic       rd_data, err, lim_full;
  logic [7:0] phase;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 jclk = ~jclk;   // 200 MHz read clock
  initial begin
    #1;
    forever begin wclk = 1'b1; #2.5; wclk = 1'b0; #2.5; end
  end
  assign rx_clk = wclk & rx_run;
  assign tx_clk = wclk & tx_run;

  bit_elastic_store u_dut (
    .rst_ni(rst_ni), .rx_clk_i(rx_clk), .tx_clk_i(tx_clk), .jclk_i(jclk),
    .dir_tx_i(dir_tx), .size_code_i(size), .center_i(center),
    .clr_err_i(clr), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .phase_o(phase), .err_o(err), .lim_full_o(lim_full)
  );

  function automatic int half_exp(input logic [2:0] c);
    return (c <= 3'd4) ? (4 << c) : 64;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge jclk);
  endtask

  task automatic do_center();
    center = 1'b1; tick(5); center = 1'b0; tick(6);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
  endtask

  task automatic wr_bits(input logic [127:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = bits[i]; tick(1);
    end
    wr_en = 1'b0; tick(6);
  endtask

  task automatic rd_bits(input logic [127:0] exp, input int n, input string req, input bit on);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1; tick(1);
      if (on) chk(req, 32'(rd_data), 32'(exp[i]));
    end
    rd_en = 1'b0; tick(6);
  endtask

  task automatic t_reset();
    chk("R2 phase", 32'(phase), 32'h0F0);
    chk("R2 err", 32'(err), 0);
    chk("R2 lim_full", 32'(lim_full), 0);
    chk("R2 rd_data", 32'(rd_data), 0);
  endtask

  task automatic t_sizes();
    for (int c = 0; c < 8; c++) begin
      int h;
      size = 3'(c);
      h = half_exp(size);
      do_center();
      pulse_clr();
      chk("R4 centred phase", 32'(phase), 0);
      wr_bits('1, 2 * h);
      chk("R1 R3 full phase", 32'(phase), 32'(h));
      chk("R6 err", 32'(err), 1);
      chk("R6 lim_full", 32'(lim_full), 1);
      if (c == 4) begin
        do_center();
        chk("R4 err kept", 32'(err), 1);
        chk("R4 lim cleared", 32'(lim_full), 0);
        chk("R4 phase", 32'(phase), 0);
        tick(10);
        chk("R8 sticky", 32'(err), 1);
        pulse_clr();
        chk("R8 cleared", 32'(err), 0);
      end
    end
  endtask

  task automatic t_underrun();
    size = 3'd2;
    do_center();
    pulse_clr();
    rd_bits('0, 32, "", 1'b0);
    chk("R3 empty phase", 32'(phase), 32'h0F0);
    chk("R7 err", 32'(err), 1);
    chk("R7 lim_full", 32'(lim_full), 0);
  endtask

  task automatic t_order();
    logic [127:0] pat;
    logic         held;
    pat = 128'hA5C3;
    size = 3'd1;
    do_center();
    pulse_clr();
    rd_bits('0, 8, "", 1'b0);
    chk("R3 drained phase", 32'(phase), 32'h0F8);
    chk("R7 no false underrun", 32'(err), 0);
    held = rd_data;
    wr_bits(pat, 16);
    chk("R3 full phase", 32'(phase), 8);
    chk("R10 idle output", 32'(rd_data), 32'(held));
    rd_bits(pat, 16, "R5 order", 1'b1);
    chk("R5 phase", 32'(phase), 32'h0F8);
    chk("R5 no error", 32'(err), 0);
  endtask

  task automatic t_ovf_drop();
    logic [127:0] pat;
    pat = 128'hB2;
    size = 3'd0;
    do_center();
    rd_bits('0, 4, "", 1'b0);
    pulse_clr();
    wr_bits(pat, 8);
    chk("R6 exact full no error", 32'(err), 0);
    wr_bits({127'b0, ~pat[7]}, 1);
    chk("R6 err", 32'(err), 1);
    chk("R6 lim_full", 32'(lim_full), 1);
    chk("R3 phase", 32'(phase), 4);
    rd_bits(pat, 8, "R6 dropped bit", 1'b1);
    rd_bits({127'b0, pat[7]}, 1, "R7 hold", 1'b1);
    chk("R7 lim_full", 32'(lim_full), 0);
    chk("R7 err", 32'(err), 1);
  endtask

  task automatic t_dir();
    size = 3'd2;
    dir_tx = 1'b0; rx_run = 1'b1; tx_run = 1'b1;
    do_center();
    pulse_clr();
    rx_run = 1'b0;
    wr_bits('1, 4);
    chk("R9 unselected clock", 32'(phase), 0);
    dir_tx = 1'b1;
    tick(2);
    wr_bits('1, 4);
    chk("R9 tx clock", 32'(phase), 4);
    rx_run = 1'b1; tx_run = 1'b0;
    tick(2);
    wr_bits('1, 2);
    chk("R9 rx ignored", 32'(phase), 4);
    dir_tx = 1'b0; tx_run = 1'b1;
    tick(2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_ni = 1'b1;
    tick(4);
    t_reset();
    t_sizes();
    t_underrun();
    t_order();
    t_ovf_drop();
    t_dir();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule